// File: doc/BRIEF.md
# Shared Memory Bus Arbiter

This block decides which of two caches, the instruction cache or the data cache, may use the single word-wide bus to main memory. Each cache raises a level request when it needs a block moved. The arbiter hands the bus to one of them and measures how long the block transfer takes. The length comes from two run-time inputs: the memory access time and the cache time. The block moves over a two-way interleaved memory, so a transfer lasts twice their sum.

A granted requester keeps the bus until its transfer ends, even if the other cache asks in the meantime. When a transfer ends, the arbiter raises a one-cycle done pulse to that requester. A request that was left waiting is granted on the next cycle. When both caches ask in the same cycle, the instruction cache is served first. Because nothing is preempted, the memory latency one cache sees depends on what the other cache is doing.

A requester is expected to drop its request within one cycle of seeing its done pulse. A cache with a registered request can only drop it one cycle late, so the arbiter ignores the finished requester's request during the done cycle.

Top module: `mem_bus_arbiter`

## Requirements
- R1: At most one grant is high at any time, and the busy flag is high exactly when a grant is held.
- R2: When the bus is idle and both requests are high in the same cycle, the instruction cache is granted.
- R3: A grant is never withdrawn before its transfer ends, even if the other cache raises a request during the transfer.
- R4: A grant stays high for exactly 2*(T+k) cycles, where T is `mem_time` and k is `cache_time`. When T+k is zero, the grant lasts 2 cycles.
- R5: Each transfer ends with a done pulse on the owner's done output only. The pulse lasts exactly one cycle and falls in the cycle right after the last grant cycle, with busy low.
- R6: During the done cycle, the request of the requester that just finished is ignored. A pending request from the other cache is granted in the following cycle.
- R7: `mem_time` and `cache_time` are sampled in the cycle the grant is issued. Changing them during a transfer does not alter its length.
- R8: While reset is high and after it is released, all outputs are low until a request is seen.
- R9: A request seen at a clock edge while the bus is idle raises the grant in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icache_req | input | 1 | Instruction cache block-transfer request (level) |
| dcache_req | input | 1 | Data cache block-transfer request (level) |
| mem_time | input | T_W | Main memory access time T in cycles |
| cache_time | input | K_W | Cache time k in cycles |
| icache_grant | output | 1 | Bus owned by the instruction cache |
| dcache_grant | output | 1 | Bus owned by the data cache |
| bus_busy | output | 1 | A transfer is in progress |
| icache_done | output | 1 | One-cycle end-of-transfer pulse to the instruction cache |
| dcache_done | output | 1 | One-cycle end-of-transfer pulse to the data cache |

## Verification
Two things can happen in the same cycle: one transfer finishes, and a request, either new or still held, is present for arbitration. The bench models caches that keep their request high one cycle past their done pulse. It then runs simultaneous requests, a data transfer interrupted by an instruction request, and single requests, across a sweep of small T and k values. Every output is compared each cycle against a timeline computed from 2*(T+k). Ordering faults and re-grant faults therefore show up as a grant or done pulse in the wrong cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_INST = 2'd1,
    OWN_DATA = 2'd2
  } owner_t;
endpackage

// File: rtl/arb_pick.sv
module arb_pick (
  input  logic inst_ok,
  input  logic data_ok,
  output logic pick_inst,
  output logic pick_data
);
  // Fixed priority: the instruction side wins a tie.
  always_comb begin
    pick_inst = inst_ok;
    pick_data = data_ok & ~inst_ok;
  end
endmodule

// File: rtl/xfer_timer.sv
module xfer_timer #(
  parameter int T_W = 4,
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           active,
  input  logic [T_W-1:0] t_cfg,
  input  logic [K_W-1:0] k_cfg,
  output logic           last
);
  localparam int S_W = ((T_W > K_W) ? T_W : K_W) + 1;
  localparam int C_W = S_W + 1;

  logic [S_W-1:0] sum;
  logic [S_W-1:0] eff;
  logic [C_W-1:0] len;
  logic [C_W-1:0] cnt;

  always_comb begin
    sum = S_W'(t_cfg) + S_W'(k_cfg);
    eff = (sum == '0) ? S_W'(1) : sum;
    len = {eff, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= len - C_W'(1);
    end else if (active && cnt != '0) begin
      cnt <= cnt - C_W'(1);
    end
  end

  assign last = active && (cnt == '0);

  // R4: the counter steps down by one each busy cycle
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !start && cnt != '0) |=> (cnt == $past(cnt) - C_W'(1)));
endmodule

// File: rtl/mem_bus_arbiter.sv
module mem_bus_arbiter #(
  parameter int T_W = 4,
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           icache_req,
  input  logic           dcache_req,
  input  logic [T_W-1:0] mem_time,
  input  logic [K_W-1:0] cache_time,
  output logic           icache_grant,
  output logic           dcache_grant,
  output logic           bus_busy,
  output logic           icache_done,
  output logic           dcache_done
);
  import arb_pkg::*;

  owner_t owner;
  logic   pick_inst, pick_data, start, last;

  // The requester that just finished is masked during its done cycle.
  arb_pick u_pick (
    .inst_ok  (icache_req & ~icache_done),
    .data_ok  (dcache_req & ~dcache_done),
    .pick_inst(pick_inst),
    .pick_data(pick_data)
  );

  assign start = ~bus_busy & (pick_inst | pick_data);

  xfer_timer #(.T_W(T_W), .K_W(K_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .active(bus_busy),
    .t_cfg (mem_time),
    .k_cfg (cache_time),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owner        <= OWN_NONE;
      bus_busy     <= 1'b0;
      icache_grant <= 1'b0;
      dcache_grant <= 1'b0;
      icache_done  <= 1'b0;
      dcache_done  <= 1'b0;
    end else begin
      icache_done <= 1'b0;
      dcache_done <= 1'b0;
      if (bus_busy) begin
        if (last) begin
          bus_busy     <= 1'b0;
          icache_grant <= 1'b0;
          dcache_grant <= 1'b0;
          icache_done  <= (owner == OWN_INST);
          dcache_done  <= (owner == OWN_DATA);
          owner        <= OWN_NONE;
        end
      end else if (start) begin
        bus_busy     <= 1'b1;
        icache_grant <= pick_inst;
        dcache_grant <= pick_data;
        owner        <= pick_inst ? OWN_INST : OWN_DATA;
      end
    end
  end

  p_one_owner_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({icache_grant, dcache_grant}));
  p_busy_match_r1: assert property (@(posedge clk) disable iff (rst)
    bus_busy == (icache_grant | dcache_grant));
  p_inst_first_r2: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && !icache_done && !dcache_done && icache_req && dcache_req) |=> icache_grant);
  p_hold_inst_r3: assert property (@(posedge clk) disable iff (rst)
    (icache_grant && !last) |=> icache_grant);
  p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
    (dcache_grant && !last) |=> dcache_grant);
  p_done_inst_r5: assert property (@(posedge clk) disable iff (rst)
    icache_done |-> ($past(icache_grant) && !bus_busy));
  p_done_data_r5: assert property (@(posedge clk) disable iff (rst)
    dcache_done |-> ($past(dcache_grant) && !bus_busy));
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (rst)
    (icache_done || dcache_done) |=> !(icache_done || dcache_done));
endmodule

// File: tb/mem_bus_arbiter_test.sv
module mem_bus_arbiter_test;
  localparam int T_W = 4;
  localparam int K_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic icache_req = 1'b0, dcache_req = 1'b0;
  logic [T_W-1:0] mem_time = '0;
  logic [K_W-1:0] cache_time = '0;
  logic icache_grant, dcache_grant, bus_busy, icache_done, dcache_done;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mem_bus_arbiter #(.T_W(T_W), .K_W(K_W)) uut (
    .clk(clk), .rst(rst),
    .icache_req(icache_req), .dcache_req(dcache_req),
    .mem_time(mem_time), .cache_time(cache_time),
    .icache_grant(icache_grant), .dcache_grant(dcache_grant),
    .bus_busy(bus_busy), .icache_done(icache_done), .dcache_done(dcache_done)
  );

  // Packed as {igrant, dgrant, busy, idone, ddone}
  function automatic logic [4:0] expect_at(int mode, int m, int len);
    logic gi, gd, di, dd;
    gi = 0; gd = 0; di = 0; dd = 0;
    case (mode)
      0, 4: begin gi = (m < len); di = (m == len); end            // R4, R9, R7
      1:    begin gd = (m < len); dd = (m == len); end            // R4, R5
      2:    begin                                                 // R2, R6
              gi = (m < len); di = (m == len);
              gd = (m >= len + 1) && (m <= 2*len); dd = (m == 2*len + 1);
            end
      default: begin                                              // R3, R6
              gd = (m < len); dd = (m == len);
              gi = (m >= len + 1) && (m <= 2*len); di = (m == 2*len + 1);
            end
    endcase
    return {gi, gd, gi | gd, di, dd};                             // R1
  endfunction

  task automatic run_case(int mode, int t, int k);
    int len, idn, ddn;
    string tag;
    logic [4:0] got, exp;
    len = 2 * (((t + k) == 0) ? 1 : (t + k));
    idn = -1; ddn = -1;
    case (mode)
      0: tag = "R4/R9"; 1: tag = "R4/R5"; 2: tag = "R2/R6";
      3: tag = "R3/R6"; default: tag = "R7";
    endcase
    @(negedge clk);
    rst = 1'b1; icache_req = 0; dcache_req = 0;
    mem_time = T_W'(t); cache_time = K_W'(k);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: outputs low after reset
    vectors++;
    got = {icache_grant, dcache_grant, bus_busy, icache_done, dcache_done};
    if (got !== 5'b0) begin
      errors++;
      $display("FAIL R8 mode %0d: got %b expected %b", mode, got, 5'b0);
    end
    for (int n = 0; n < 2*len + 6; n++) begin
      if (n > 0) begin
        @(negedge clk);
        got = {icache_grant, dcache_grant, bus_busy, icache_done, dcache_done};
        exp = expect_at(mode, n - 1, len);
        vectors++;
        if (got !== exp) begin
          errors++;
          $display("FAIL %s mode %0d T=%0d k=%0d cycle %0d: got %b expected %b",
                   tag, mode, t, k, n - 1, got, exp);
        end
        if (icache_done && idn < 0) idn = n - 1;
        if (dcache_done && ddn < 0) ddn = n - 1;
      end
      // Caches drop their request one cycle after seeing done (R6 mask)
      icache_req = (mode == 0 || mode == 2 || mode == 4 || (mode == 3 && n >= 1))
                   && (idn < 0 || n <= idn + 1);
      dcache_req = (mode == 1 || mode == 2 || mode == 3) && (ddn < 0 || n <= ddn + 1);
      if (mode == 4 && n >= 1) begin  // R7: change config mid-transfer
        mem_time = '1; cache_time = '1;
      end
    end
    icache_req = 0; dcache_req = 0;
  endtask

  initial begin
    for (int mode = 0; mode < 5; mode++)
      for (int t = 0; t < 4; t++)
        for (int k = 0; k < 4; k++)
          run_case(mode, t, k);
    finished = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule